// File: doc/BRIEF.md
# Breakpoint Debug Event Unit

This unit sits beside a processor core. It compares the core's instruction fetch address and its data bus accesses against compare registers that software programs. When a compare hits and its enable bit is set, the unit raises a debug event. The event is logged in a sticky status register and is also pulsed on a watchpoint output, so a trace unit can use it. A dedicated input raises an event from outside the core, whatever the compare registers hold.

One mode bit decides what an event does. In software debug mode the core keeps running: the unit raises a level debug interrupt when interrupts are enabled, and otherwise only logs the event. In external debug mode the same event halts the core. A resume request releases the core only when no enabled status flag is still set, so a flag left uncleared holds the core in debug mode. A step request lets a halted core fetch exactly one instruction, and then the core halts again.

Software reaches the configuration, the status and the compare registers through a simple register port. A write takes effect on the clock edge, and a read returns data combinationally.

Top module: `dbg_event_unit`

## Requirements
- R1: A word offset 8+i holds an instruction compare address. An instruction compare i hits when `ifetch_valid` is high and address bits [31:2] equal the compare value, so the byte offset within the word is ignored. The hit counts as an event only when the enable bit 8+i of the control register (offset 0) is set.
- R2: An event sets status bit i (offset 1) on the next clock edge. The bit stays set until software clears it. Status bits map as follows: bits 0..N_IBP-1 are the instruction compares, then data address, then data value, then external event. With N_IBP=2 these are bits 2, 3 and 4.
- R3: When control bit 0 is 0 (software mode), the core is never halted. `dbg_irq` is high exactly when control bit 1 (interrupt enable) is set and some enabled status bit is set.
- R4: When control bit 0 is 1 (external mode), an event halts the core (`core_halt`=1) from the cycle after the event. `dbg_irq` stays low.
- R5: While the core is halted, a resume request returns it to running only if no enabled status bit is set at that cycle. Otherwise the core stays halted.
- R6: The data address compare (offset 2, enable bit 8+N_IBP) hits on `dacc_valid` when address bits [31:2] match.
- R7: The data value compare (value at offset 3, byte mask in bits 3:0 of offset 4, enable bit 9+N_IBP) hits on `dacc_valid` when every byte whose mask bit is 1 equals the compare value.
- R8: A high `ext_evt_in` raises the external event in every mode. It does not depend on any enable bit or compare result.
- R9: A step request in the halted state releases the core until one `ifetch_valid` cycle has passed. The core is then halted again.
- R10: Writing ones to the status register clears those bits. An event in the same cycle as the clear leaves its bit set.
- R11: `watch_o` shows the events of a cycle for exactly one cycle, in the cycle after they occur.
- R12: After reset, the control register, the status register and all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ifetch_valid | input | 1 | Instruction fetch in this cycle |
| ifetch_addr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Load/store access in this cycle |
| dacc_addr | input | 32 | Data access address |
| dacc_data | input | 32 | Data access value |
| ext_evt_in | input | 1 | External debug event request |
| step_req | input | 1 | Single-step request while halted |
| resume_req | input | 1 | Leave debug mode request |
| core_halt | output | 1 | Core held in debug mode |
| dbg_irq | output | 1 | Debug interrupt request (level) |
| watch_o | output | N_IBP+3 | One-cycle watchpoint pulses per event |

## Verification
The bench builds the unit with its defaults: two instruction compares and 32-bit words. This gives a five-bit event vector, so every status position, including the external bit at 4, can be checked literally. With two instruction comparators, the bench can check that an armed compare and a disabled one stay independent. Random register contents and bus traffic exercise the byte-mask and word-alignment paths. Directed sequences cover the halt, blocked-resume, step and same-cycle clear orderings.

// File: rtl/dbg_pkg.sv
// Shared constants and types for the breakpoint debug event unit.
// Assumes a 4-bit register word offset.
package dbg_pkg;
    localparam int REG_AW       = 4;
    localparam int OFS_CTRL     = 0;
    localparam int OFS_STATUS   = 1;
    localparam int OFS_DADDR    = 2;
    localparam int OFS_DVALUE   = 3;
    localparam int OFS_DMASK    = 4;
    localparam int OFS_IADDR0   = 8;
    localparam int CTRL_EN_LSB  = 8;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STEP = 2'd2
    } run_state_e;
endpackage

// File: rtl/dbg_match.sv
// Comparator bank. It produces raw (unmasked) event hits for one cycle.
// Assumes that addresses are compared on word granularity (bits [W-1:2]).
module dbg_match #(
    parameter int W   = 32,
    parameter int NI  = 2
) (
    input  logic              ifetch_valid,
    input  logic [W-1:0]      ifetch_addr,
    input  logic              dacc_valid,
    input  logic [W-1:0]      dacc_addr,
    input  logic [W-1:0]      dacc_data,
    input  logic [NI*W-1:0]   iadr_flat,
    input  logic [W-1:0]      dadr,
    input  logic [W-1:0]      dval,
    input  logic [W/8-1:0]    dmask,
    input  logic              ext_evt,
    output logic [NI+2:0]     raw
);
    localparam int NB = W / 8;

    logic [NB-1:0] byte_ok;

    genvar gi;
    generate
        for (gi = 0; gi < NI; gi++) begin : g_icmp
            // instruction compare gi on word address
            assign raw[gi] = ifetch_valid &&
                (ifetch_addr[W-1:2] == iadr_flat[gi*W+2 +: W-2]);
        end
        for (gi = 0; gi < NB; gi++) begin : g_byte
            // a masked-out byte always agrees
            assign byte_ok[gi] = !dmask[gi] ||
                (dacc_data[gi*8 +: 8] == dval[gi*8 +: 8]);
        end
    endgenerate

    // data address, data value and external event hits
    assign raw[NI]   = dacc_valid && (dacc_addr[W-1:2] == dadr[W-1:2]);
    assign raw[NI+1] = dacc_valid && (&byte_ok);
    assign raw[NI+2] = ext_evt;
endmodule

// File: rtl/dbg_cfg_regs.sv
// Register file: control, sticky status (write-one-to-clear), compare values.
// Assumes that a new event wins over a clear of the same bit in one cycle.
module dbg_cfg_regs
    import dbg_pkg::*;
#(
    parameter int W  = 32,
    parameter int NI = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [REG_AW-1:0]   addr,
    input  logic [W-1:0]        wdata,
    output logic [W-1:0]        rdata,
    input  logic [NI+2:0]       hit,
    output logic                ext_mode,
    output logic                irq_en,
    output logic [NI+2:0]       en_mask,
    output logic [NI+2:0]       status,
    output logic [NI*W-1:0]     iadr_flat,
    output logic [W-1:0]        dadr,
    output logic [W-1:0]        dval,
    output logic [W/8-1:0]      dmask
);
    localparam int NEV = NI + 3;
    localparam int NB  = W / 8;

    logic [NEV-2:0] cmp_en;
    logic [NEV-1:0] clr;

    assign en_mask = {1'b1, cmp_en};
    assign clr = (we && addr == REG_AW'(OFS_STATUS)) ? wdata[NEV-1:0] : '0;

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_mode <= 1'b0;
            irq_en   <= 1'b0;
            cmp_en   <= '0;
        end else if (we && addr == REG_AW'(OFS_CTRL)) begin
            ext_mode <= wdata[0];
            irq_en   <= wdata[1];
            cmp_en   <= wdata[CTRL_EN_LSB +: NEV-1];
        end
    end

    // sticky status: clear first, then set by new events
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | hit;
    end

    // data compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dadr  <= '0;
            dval  <= '0;
            dmask <= '0;
        end else if (we) begin
            if (addr == REG_AW'(OFS_DADDR))  dadr  <= wdata;
            if (addr == REG_AW'(OFS_DVALUE)) dval  <= wdata;
            if (addr == REG_AW'(OFS_DMASK))  dmask <= wdata[NB-1:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NI; gi++) begin : g_iadr
            // instruction compare register gi
            always_ff @(posedge clk) begin
                if (!rst_n)
                    iadr_flat[gi*W +: W] <= '0;
                else if (we && addr == REG_AW'(OFS_IADDR0 + gi))
                    iadr_flat[gi*W +: W] <= wdata;
            end
        end
    endgenerate

    // read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == REG_AW'(OFS_CTRL)) begin
            rdata[0] = ext_mode;
            rdata[1] = irq_en;
            rdata[CTRL_EN_LSB +: NEV-1] = cmp_en;
        end
        if (addr == REG_AW'(OFS_STATUS)) rdata[NEV-1:0] = status;
        if (addr == REG_AW'(OFS_DADDR))  rdata = dadr;
        if (addr == REG_AW'(OFS_DVALUE)) rdata = dval;
        if (addr == REG_AW'(OFS_DMASK))  rdata[NB-1:0] = dmask;
        for (int i = 0; i < NI; i++)
            if (addr == REG_AW'(OFS_IADDR0 + i)) rdata = iadr_flat[i*W +: W];
    end
endmodule

// File: rtl/dbg_run_ctrl.sv
// Halt/resume/step state machine for external debug mode.
// Assumes that one ifetch_valid cycle marks one executed instruction.
module dbg_run_ctrl
    import dbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_mode,
    input  logic        any_hit,
    input  logic        pending,
    input  logic        resume_req,
    input  logic        step_req,
    input  logic        ifetch_valid,
    output logic        core_halt,
    output run_state_e  state
);
    run_state_e nxt;

    // next-state selection
    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:  if (ext_mode && any_hit) nxt = ST_HALT;
            ST_HALT: begin
                if (step_req)                 nxt = ST_STEP;
                else if (resume_req && !pending) nxt = ST_RUN;
            end
            ST_STEP: if (ifetch_valid || (ext_mode && any_hit)) nxt = ST_HALT;
            default: nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    assign core_halt = (state == ST_HALT);
endmodule

// File: rtl/dbg_event_unit.sv
// Top of the breakpoint debug event unit: comparators, registers, run control.
// Assumes that address and data words have the same width W.
module dbg_event_unit
    import dbg_pkg::*;
#(
    parameter int W     = 32,
    parameter int N_IBP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [W-1:0]        reg_wdata,
    output logic [W-1:0]        reg_rdata,
    input  logic                ifetch_valid,
    input  logic [W-1:0]        ifetch_addr,
    input  logic                dacc_valid,
    input  logic [W-1:0]        dacc_addr,
    input  logic [W-1:0]        dacc_data,
    input  logic                ext_evt_in,
    input  logic                step_req,
    input  logic                resume_req,
    output logic                core_halt,
    output logic                dbg_irq,
    output logic [N_IBP+2:0]    watch_o
);
    localparam int NEV = N_IBP + 3;

    logic [NEV-1:0]     raw, hit, en_mask, status;
    logic               ext_mode, irq_en, pending;
    logic [N_IBP*W-1:0] iadr_flat;
    logic [W-1:0]       dadr, dval;
    logic [W/8-1:0]     dmask;
    run_state_e         state;

    dbg_match #(.W(W), .NI(N_IBP)) u_match (
        .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_data(dacc_data),
        .iadr_flat(iadr_flat), .dadr(dadr), .dval(dval), .dmask(dmask),
        .ext_evt(ext_evt_in), .raw(raw)
    );

    assign hit     = raw & en_mask;
    assign pending = |(status & en_mask);

    dbg_cfg_regs #(.W(W), .NI(N_IBP)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .hit(hit),
        .ext_mode(ext_mode), .irq_en(irq_en), .en_mask(en_mask),
        .status(status), .iadr_flat(iadr_flat), .dadr(dadr),
        .dval(dval), .dmask(dmask)
    );

    dbg_run_ctrl u_run (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .any_hit(|hit),
        .pending(pending), .resume_req(resume_req), .step_req(step_req),
        .ifetch_valid(ifetch_valid), .core_halt(core_halt), .state(state)
    );

    // one-cycle watchpoint pulses
    always_ff @(posedge clk) begin
        if (!rst_n) watch_o <= '0;
        else        watch_o <= hit;
    end

    assign dbg_irq = !ext_mode && irq_en && pending;
endmodule

// File: rtl/dbg_event_unit_chk.sv
// Temporal checks for dbg_event_unit, attached by bind.
module dbg_event_unit_chk
    import dbg_pkg::*;
#(
    parameter int NEV = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            core_halt,
    input logic            ext_mode,
    input logic            resume_req,
    input logic            step_req,
    input logic            ifetch_valid,
    input logic            ext_evt_in,
    input logic [NEV-1:0]  status,
    input logic [NEV-1:0]  en_mask,
    input logic [NEV-1:0]  watch_o,
    input run_state_e      state
);
    AST_HALT_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_halt) |-> $past(ext_mode));  // R4
    AST_RESUME_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && resume_req && !step_req && |(status & en_mask)) |=> core_halt);  // R5
    AST_EXT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt_in |=> status[NEV-1]);  // R8
    AST_STEP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && ifetch_valid) |=> core_halt);  // R9
    AST_WATCH_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_o & ~status) == '0);  // R11
endmodule

bind dbg_event_unit dbg_event_unit_chk #(.NEV(N_IBP + 3)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .ext_mode(ext_mode),
    .resume_req(resume_req), .step_req(step_req), .ifetch_valid(ifetch_valid),
    .ext_evt_in(ext_evt_in), .status(status), .en_mask(en_mask),
    .watch_o(watch_o), .state(state)
);

// File: tb/test_dbg_event_unit.sv
`timescale 1ns/1ps
module test_dbg_event_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ifetch_valid = 1'b0;
    logic [31:0] ifetch_addr = '0;
    logic        dacc_valid = 1'b0;
    logic [31:0] dacc_addr = '0;
    logic [31:0] dacc_data = '0;
    logic        ext_evt_in = 1'b0;
    logic        step_req = 1'b0;
    logic        resume_req = 1'b0;
    logic        core_halt, dbg_irq;
    logic [4:0]  watch_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_iadr [2];
    logic [31:0] m_dadr, m_dval;
    logic [3:0]  m_dmsk, m_en;
    logic        m_irqen;

    always #4 clk = ~clk;

    dbg_event_unit i_dbg_event_unit (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cyc(input logic fv, input logic [31:0] fa, input logic dv,
                       input logic [31:0] da, input logic [31:0] dd,
                       input logic ev, input logic rs, input logic st);
        ifetch_valid = fv; ifetch_addr = fa; dacc_valid = dv; dacc_addr = da;
        dacc_data = dd; ext_evt_in = ev; resume_req = rs; step_req = st;
        @(negedge clk);
        ifetch_valid = 0; dacc_valid = 0; ext_evt_in = 0; resume_req = 0; step_req = 0;
    endtask

    function automatic logic [4:0] exp_hits(input logic fv, input logic [31:0] fa,
            input logic dv, input logic [31:0] da, input logic [31:0] dd, input logic ev);
        logic [4:0] h = '0;
        logic ok = 1'b1;
        for (int i = 0; i < 2; i++)
            if (fv && fa[31:2] == m_iadr[i][31:2] && m_en[i]) h[i] = 1'b1;
        if (dv && da[31:2] == m_dadr[31:2] && m_en[2]) h[2] = 1'b1;
        for (int b = 0; b < 4; b++)
            if (m_dmsk[b] && dd[b*8 +: 8] != m_dval[b*8 +: 8]) ok = 1'b0;
        if (dv && ok && m_en[3]) h[3] = 1'b1;
        if (ev) h[4] = 1'b1;
        return h;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [4:0]  eh;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(4'd0, v); check("R12 ctrl", v, 0);
        rd(4'd1, v); check("R12 status", v, 0);
        check("R12 halt", {31'b0, core_halt}, 0);
        check("R12 irq", {31'b0, dbg_irq}, 0);
        check("R12 watch", {27'b0, watch_o}, 0);

        // R1 R2 R11 instruction compare, software mode
        wr(4'd8, 32'h1000); wr(4'd9, 32'h2000); wr(4'd0, 32'h100);
        cyc(1, 32'h1002, 0, 0, 0, 0, 0, 0);
        check("R11 watch pulse", {27'b0, watch_o}, 32'h1);
        rd(4'd1, v); check("R1 R2 status set", v, 32'h1);
        check("R3 no irq when disabled", {31'b0, dbg_irq}, 0);
        check("R3 no halt in software mode", {31'b0, core_halt}, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        check("R11 pulse ends", {27'b0, watch_o}, 0);
        rd(4'd1, v); check("R2 sticky", v, 32'h1);
        cyc(1, 32'h2000, 0, 0, 0, 0, 0, 0);
        check("R1 disabled compare", {27'b0, watch_o}, 0);
        cyc(1, 32'h1004, 0, 0, 0, 0, 0, 0);
        check("R1 next word no hit", {27'b0, watch_o}, 0);

        // R3 interrupt level, R10 clear
        wr(4'd0, 32'h102);
        check("R3 irq raised", {31'b0, dbg_irq}, 1);
        wr(4'd1, 32'h1F);
        rd(4'd1, v); check("R10 cleared", v, 0);
        check("R3 irq dropped", {31'b0, dbg_irq}, 0);

        // R10 event wins over same-cycle clear
        reg_we = 1; reg_addr = 4'd1; reg_wdata = 32'h1F;
        cyc(1, 32'h1000, 0, 0, 0, 0, 0, 0);
        reg_we = 0;
        rd(4'd1, v); check("R10 event wins", v, 32'h1);
        wr(4'd1, 32'h1F);

        // R6 R7 data compares
        wr(4'd0, 32'hC00); wr(4'd2, 32'h4000); wr(4'd3, 32'hAABBCCDD); wr(4'd4, 32'h3);
        cyc(0, 0, 1, 32'h4001, 32'h1122CCDD, 0, 0, 0);
        check("R6 R7 both data hits", {27'b0, watch_o}, 32'hC);
        wr(4'd1, 32'h1F);
        cyc(0, 0, 1, 32'h5000, 32'h1122CC00, 0, 0, 0);
        check("R6 R7 no data hit", {27'b0, watch_o}, 0);
        cyc(0, 0, 0, 32'h4000, 32'hAABBCCDD, 0, 0, 0);
        check("R6 needs dacc_valid", {27'b0, watch_o}, 0);

        // R4 R5 external mode halt and blocked resume
        wr(4'd0, 32'h103);
        cyc(1, 32'h1000, 0, 0, 0, 0, 0, 0);
        check("R4 halted", {31'b0, core_halt}, 1);
        check("R4 no irq", {31'b0, dbg_irq}, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check("R5 resume blocked", {31'b0, core_halt}, 1);
        wr(4'd1, 32'h1F);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check("R5 resume after clear", {31'b0, core_halt}, 0);

        // R8 R9 external event halt and single step
        wr(4'd0, 32'h001);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        check("R8 ext halts", {31'b0, core_halt}, 1);
        rd(4'd1, v); check("R8 ext status", v, 32'h10);
        wr(4'd1, 32'h1F);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        check("R9 step releases", {31'b0, core_halt}, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        check("R9 waits for fetch", {31'b0, core_halt}, 0);
        cyc(1, 32'h3000, 0, 0, 0, 0, 0, 0);
        check("R9 halts after one", {31'b0, core_halt}, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check("R5 resume no pending", {31'b0, core_halt}, 0);

        // R8 in software mode
        wr(4'd0, 32'h0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        rd(4'd1, v); check("R8 ext logged soft", v, 32'h10);
        check("R3 soft no halt", {31'b0, core_halt}, 0);
        wr(4'd1, 32'h1F);

        // random traffic in software mode: R1 R3 R6 R7 R11
        for (int it = 0; it < 60; it++) begin
            logic fv, dv, ev;
            logic [31:0] fa, da, dd, mb;
            m_iadr[0] = $urandom; m_iadr[1] = $urandom;
            m_dadr = $urandom; m_dval = $urandom;
            m_dmsk = 4'($urandom); m_en = 4'($urandom); m_irqen = 1'($urandom);
            wr(4'd8, m_iadr[0]); wr(4'd9, m_iadr[1]);
            wr(4'd2, m_dadr); wr(4'd3, m_dval); wr(4'd4, {28'b0, m_dmsk});
            wr(4'd0, {20'b0, m_en, 6'b0, m_irqen, 1'b0});
            wr(4'd1, 32'h1F);
            mb = {{8{m_dmsk[3]}}, {8{m_dmsk[2]}}, {8{m_dmsk[1]}}, {8{m_dmsk[0]}}};
            fv = 1'($urandom); dv = 1'($urandom); ev = ($urandom % 8) == 0;
            fa = ($urandom % 2) ? (m_iadr[$urandom % 2] ^ ($urandom % 4)) : $urandom;
            da = ($urandom % 2) ? (m_dadr ^ ($urandom % 4)) : $urandom;
            dd = ($urandom % 2) ? ((m_dval & mb) | ($urandom & ~mb)) : $urandom;
            eh = exp_hits(fv, fa, dv, da, dd, ev);
            cyc(fv, fa, dv, da, dd, ev, 0, 0);
            check("R1 R6 R7 R11 random watch", {27'b0, watch_o}, {27'b0, eh});
            rd(4'd1, v); check("R2 random status", v, {27'b0, eh});
            check("R3 random irq", {31'b0, dbg_irq}, {31'b0, m_irqen && (|eh)});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule